// File: doc/BRIEF.md
# Multi-Level Sequential Trigger Sequencer

This block decides when a logic-capture front end should stop and keep what it has seen. It looks at a sampled data word on every cycle where a sample-valid strobe is high and walks through an ordered set of sequence levels. Each level stands for one stage of a hunt that unfolds over time, such as "wait for the first bus command" followed by "now watch for a missing refresh". At any moment only the current level is active. Its branches are all tested against the same sample, and the first branch whose condition holds picks the action for that sample.

A branch condition compares the masked data word with a constant. It can also require an active-low qualifier input to be low, and it can require the level's sample counter to have reached that level's limit. Because sampling runs at a fixed rate, this counter stands in for a timer. A level can therefore fire when an expected pattern stops showing up: one branch clears the counter each time the pattern appears, and a second branch fires once the counter reaches the limit.

Configuration is written through a simple write port, one branch or one level limit per cycle. An arm input restarts a hunt.

Top module: `tsq_trigger_seq`

## Requirements
- R1: After reset, `cur_level` is 0, `triggered` is 0 and `trig_pulse` is 0. Every branch is cleared to mask 0, value 0, qualifier and timeout off, action code 0, target 0. Every level limit is 0.
- R2: On a cycle where `smp_valid` is low (and `arm` is low), `cur_level`, `triggered` and the level counter keep their values, and `trig_pulse` is low on the next cycle.
- R3: A branch's pattern holds when `((smp_data ^ value) & mask) == 0`. If the branch's qualifier enable is set, the branch also needs `smp_qual_n` to be 0.
- R4: Branch 0 of a level has priority over branch 1. Only the action of the lowest-numbered true branch is taken for a sample.
- R5: Action code 0 (go to) loads the branch's target into `cur_level` at the sampling edge and clears the counter.
- R6: Action code 1 (stay) keeps the level, and the counter keeps counting.
- R7: Action code 2 (clear) keeps the level and sets the counter to 0.
- R8: The counter counts valid samples evaluated in the current level since its last clear, and it saturates at its maximum value. A branch with the timeout option set is true only while the counter is at least the level's limit. With limit L, the (L+1)-th valid sample after a clear meets this condition.
- R9: Action code 3 (fire) drives `trig_pulse` high for exactly one cycle, in the cycle after the sample, and sets `triggered`. `triggered` stays high until arm. While it is high, samples change nothing.
- R10: `arm` high sets the level to 0 and clears the counter and `triggered` at the next edge. It takes priority over a sample in the same cycle.
- R11: When no branch of the current level is true, the level stays the same and the counter advances.
- R12: A configuration write is applied at the clock edge, and samples from the next cycle onwards use it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arm | input | 1 | Restart the hunt at level 0 |
| smp_valid | input | 1 | Sample strobe; one step is evaluated when high |
| smp_data | input | DATA_W | Sampled data word |
| smp_qual_n | input | 1 | Active-low qualifier line |
| cfg_br_we | input | 1 | Write one branch |
| cfg_lim_we | input | 1 | Write one level limit |
| cfg_lvl | input | LVL_W | Level addressed by a write |
| cfg_br | input | BR_W | Branch addressed by a branch write |
| cfg_mask | input | DATA_W | Compare mask (1 = bit compared) |
| cfg_value | input | DATA_W | Compare value |
| cfg_qual_en | input | 1 | Branch requires `smp_qual_n` low |
| cfg_on_tmo | input | 1 | Branch requires counter >= level limit |
| cfg_action | input | 2 | 0 go to, 1 stay, 2 clear counter, 3 fire |
| cfg_target | input | LVL_W | Destination level for go to |
| cfg_limit | input | CNT_W | Level limit for the timeout test |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Sticky triggered flag |
| cur_level | output | LVL_W | Current sequence level |

## Verification
The bench targets the exact cycle of a timeout. It clears the counter part-way through a run and then counts samples up to the limit. A design that is off by one, or that ignores the clear, fires a sample early or late. It also drives samples that satisfy both branches at once, so a design with the priority reversed takes the wrong branch's action and lands in the wrong level. It drives a pattern match while the qualifier is inactive, which a design that ignores the qualifier would accept. It raises arm in the same cycle as a firing sample, and a design that gives the sample priority would report a trigger. A long random phase re-arms and rewrites the configuration while the engine runs, and a model compares every cycle. This catches a counter that does not freeze on idle cycles, a flag that clears itself, and a configuration change that takes effect a cycle early.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  typedef enum logic [1:0] {
    ACT_GOTO = 2'd0,
    ACT_STAY = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_FIRE = 2'd3
  } tsq_act_e;
endpackage

// File: rtl/tsq_cfg_store.sv
module tsq_cfg_store #(
  parameter int LEVELS   = 4,
  parameter int BRANCHES = 2,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int BR_W    = (BRANCHES > 1) ? $clog2(BRANCHES) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              br_we,
  input  logic                              lim_we,
  input  logic [LVL_W-1:0]                  wr_lvl,
  input  logic [BR_W-1:0]                   wr_br,
  input  logic [DATA_W-1:0]                 wr_mask,
  input  logic [DATA_W-1:0]                 wr_value,
  input  logic                              wr_qual_en,
  input  logic                              wr_on_tmo,
  input  logic [1:0]                        wr_act,
  input  logic [LVL_W-1:0]                  wr_tgt,
  input  logic [CNT_W-1:0]                  wr_limit,
  input  logic [LVL_W-1:0]                  rd_lvl,
  output logic [BRANCHES-1:0][DATA_W-1:0]   rd_mask,
  output logic [BRANCHES-1:0][DATA_W-1:0]   rd_value,
  output logic [BRANCHES-1:0]               rd_qual_en,
  output logic [BRANCHES-1:0]               rd_on_tmo,
  output logic [BRANCHES-1:0][1:0]          rd_act,
  output logic [BRANCHES-1:0][LVL_W-1:0]    rd_tgt,
  output logic [CNT_W-1:0]                  rd_limit
);

  logic [DATA_W-1:0] mask_q  [LEVELS][BRANCHES];
  logic [DATA_W-1:0] value_q [LEVELS][BRANCHES];
  logic              qual_q  [LEVELS][BRANCHES];
  logic              tmo_q   [LEVELS][BRANCHES];
  logic [1:0]        act_q   [LEVELS][BRANCHES];
  logic [LVL_W-1:0]  tgt_q   [LEVELS][BRANCHES];
  logic [CNT_W-1:0]  lim_q   [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    logic lvl_sel;
    assign lvl_sel = (wr_lvl == LVL_W'(l));

    for (genvar b = 0; b < BRANCHES; b++) begin : g_br
      logic br_en;
      assign br_en = br_we & lvl_sel & (wr_br == BR_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mask_q[l][b]  <= '0;
          value_q[l][b] <= '0;
          qual_q[l][b]  <= 1'b0;
          tmo_q[l][b]   <= 1'b0;
          act_q[l][b]   <= 2'd0;
          tgt_q[l][b]   <= '0;
        end else if (br_en) begin
          mask_q[l][b]  <= wr_mask;
          value_q[l][b] <= wr_value;
          qual_q[l][b]  <= wr_qual_en;
          tmo_q[l][b]   <= wr_on_tmo;
          act_q[l][b]   <= wr_act;
          tgt_q[l][b]   <= wr_tgt;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lim_q[l] <= '0;
      end else if (lim_we && lvl_sel) begin
        lim_q[l] <= wr_limit;
      end
    end
  end

  // read port: the branch set of one level, selected without a wide index
  always_comb begin
    rd_mask    = '0;
    rd_value   = '0;
    rd_qual_en = '0;
    rd_on_tmo  = '0;
    rd_act     = '0;
    rd_tgt     = '0;
    rd_limit   = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (rd_lvl == LVL_W'(l)) begin
        rd_limit = lim_q[l];
        for (int b = 0; b < BRANCHES; b++) begin
          rd_mask[b]    = mask_q[l][b];
          rd_value[b]   = value_q[l][b];
          rd_qual_en[b] = qual_q[l][b];
          rd_on_tmo[b]  = tmo_q[l][b];
          rd_act[b]     = act_q[l][b];
          rd_tgt[b]     = tgt_q[l][b];
        end
      end
    end
  end

endmodule

// File: rtl/tsq_branch_eval.sv
module tsq_branch_eval #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] data,
  input  logic              qual_n,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] value,
  input  logic              qual_en,
  input  logic              on_tmo,
  input  logic              tmo_hit,
  output logic              hit
);

  logic pat_ok;
  logic qual_ok;
  logic tmo_ok;

  always_comb begin
    pat_ok  = (((data ^ value) & mask) == '0);
    qual_ok = ~qual_en | ~qual_n;
    tmo_ok  = ~on_tmo | tmo_hit;
    hit     = pat_ok & qual_ok & tmo_ok;
  end

endmodule

// File: rtl/tsq_prio_pick.sv
module tsq_prio_pick #(
  parameter int N  = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/tsq_trigger_seq.sv
module tsq_trigger_seq #(
  parameter int LEVELS   = 4,
  parameter int BRANCHES = 2,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int BR_W    = (BRANCHES > 1) ? $clog2(BRANCHES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_qual_n,
  input  logic              cfg_br_we,
  input  logic              cfg_lim_we,
  input  logic [LVL_W-1:0]  cfg_lvl,
  input  logic [BR_W-1:0]   cfg_br,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic [DATA_W-1:0] cfg_value,
  input  logic              cfg_qual_en,
  input  logic              cfg_on_tmo,
  input  logic [1:0]        cfg_action,
  input  logic [LVL_W-1:0]  cfg_target,
  input  logic [CNT_W-1:0]  cfg_limit,
  output logic              trig_pulse,
  output logic              triggered,
  output logic [LVL_W-1:0]  cur_level
);
  import tsq_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q, rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i_n = rst_s2_q;

  // state
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             trg_q, trg_d;
  logic             pls_q, pls_d;
  logic             state_en;

  // configuration of the active level
  logic [BRANCHES-1:0][DATA_W-1:0] br_mask;
  logic [BRANCHES-1:0][DATA_W-1:0] br_value;
  logic [BRANCHES-1:0]             br_qual_en;
  logic [BRANCHES-1:0]             br_on_tmo;
  logic [BRANCHES-1:0][1:0]        br_act;
  logic [BRANCHES-1:0][LVL_W-1:0]  br_tgt;
  logic [CNT_W-1:0]                lvl_limit;

  tsq_cfg_store #(
    .LEVELS   (LEVELS),
    .BRANCHES (BRANCHES),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .br_we      (cfg_br_we),
    .lim_we     (cfg_lim_we),
    .wr_lvl     (cfg_lvl),
    .wr_br      (cfg_br),
    .wr_mask    (cfg_mask),
    .wr_value   (cfg_value),
    .wr_qual_en (cfg_qual_en),
    .wr_on_tmo  (cfg_on_tmo),
    .wr_act     (cfg_action),
    .wr_tgt     (cfg_target),
    .wr_limit   (cfg_limit),
    .rd_lvl     (lvl_q),
    .rd_mask    (br_mask),
    .rd_value   (br_value),
    .rd_qual_en (br_qual_en),
    .rd_on_tmo  (br_on_tmo),
    .rd_act     (br_act),
    .rd_tgt     (br_tgt),
    .rd_limit   (lvl_limit)
  );

  // branch conditions, one evaluator per branch
  logic                tmo_hit;
  logic [BRANCHES-1:0] br_hit;

  assign tmo_hit = (cnt_q >= lvl_limit);

  for (genvar b = 0; b < BRANCHES; b++) begin : g_eval
    tsq_branch_eval #(.DATA_W(DATA_W)) u_eval (
      .data    (smp_data),
      .qual_n  (smp_qual_n),
      .mask    (br_mask[b]),
      .value   (br_value[b]),
      .qual_en (br_qual_en[b]),
      .on_tmo  (br_on_tmo[b]),
      .tmo_hit (tmo_hit),
      .hit     (br_hit[b])
    );
  end

  logic            sel_any;
  logic [BR_W-1:0] sel_idx;

  tsq_prio_pick #(.N(BRANCHES)) u_pick (
    .req (br_hit),
    .any (sel_any),
    .idx (sel_idx)
  );

  // next state
  tsq_act_e   sel_act;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    sel_act  = tsq_act_e'(br_act[sel_idx]);
    cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    state_en = arm | (smp_valid & ~trg_q);
    lvl_d    = lvl_q;
    cnt_d    = cnt_q;
    trg_d    = trg_q;
    pls_d    = 1'b0;
    if (arm) begin
      lvl_d = '0;
      cnt_d = '0;
      trg_d = 1'b0;
    end else if (smp_valid && !trg_q) begin
      cnt_d = cnt_inc;
      if (sel_any) begin
        unique case (sel_act)
          ACT_GOTO: begin
            lvl_d = br_tgt[sel_idx];
            cnt_d = '0;
          end
          ACT_STAY: ;
          ACT_CLR:  cnt_d = '0;
          ACT_FIRE: begin
            trg_d = 1'b1;
            pls_d = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      lvl_q <= '0;
      cnt_q <= '0;
      trg_q <= 1'b0;
    end else if (state_en) begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
      trg_q <= trg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pls_q <= 1'b0;
    end else begin
      pls_q <= pls_d;
    end
  end

  assign trig_pulse = pls_q;
  assign triggered  = trg_q;
  assign cur_level  = lvl_q;

endmodule

// File: rtl/tsq_trigger_seq_chk.sv
module tsq_trigger_seq_chk #(
  parameter int LVL_BITS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                arm,
  input logic                smp_valid,
  input logic                trig_pulse,
  input logic                triggered,
  input logic [LVL_BITS-1:0] cur_level
);

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  // R9
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> triggered);

  // R9
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(triggered) |-> trig_pulse);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && !arm) |=> (triggered && $stable(cur_level)));

  // R10
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (cur_level == '0 && !triggered && !trig_pulse));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !arm) |=> ($stable(cur_level) && $stable(triggered) && !trig_pulse));

endmodule

bind tsq_trigger_seq tsq_trigger_seq_chk #(.LVL_BITS(LVL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arm        (arm),
  .smp_valid  (smp_valid),
  .trig_pulse (trig_pulse),
  .triggered  (triggered),
  .cur_level  (cur_level)
);

// File: tb/tsq_trigger_seq_bench.sv
`timescale 1ns/1ps
module tsq_trigger_seq_bench;
  localparam int L  = 4;
  localparam int B  = 2;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int LW = 2;
  localparam int BW = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm = 1'b0;
  logic          smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          smp_qual_n = 1'b1;
  logic          cfg_br_we = 1'b0;
  logic          cfg_lim_we = 1'b0;
  logic [LW-1:0] cfg_lvl = '0;
  logic [BW-1:0] cfg_br = '0;
  logic [DW-1:0] cfg_mask = '0;
  logic [DW-1:0] cfg_value = '0;
  logic          cfg_qual_en = 1'b0;
  logic          cfg_on_tmo = 1'b0;
  logic [1:0]    cfg_action = '0;
  logic [LW-1:0] cfg_target = '0;
  logic [CW-1:0] cfg_limit = '0;
  logic          trig_pulse;
  logic          triggered;
  logic [LW-1:0] cur_level;

  always #2 clk = ~clk;

  tsq_trigger_seq u_tsq_trigger_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_valid(smp_valid),
    .smp_data(smp_data), .smp_qual_n(smp_qual_n),
    .cfg_br_we(cfg_br_we), .cfg_lim_we(cfg_lim_we), .cfg_lvl(cfg_lvl),
    .cfg_br(cfg_br), .cfg_mask(cfg_mask), .cfg_value(cfg_value),
    .cfg_qual_en(cfg_qual_en), .cfg_on_tmo(cfg_on_tmo),
    .cfg_action(cfg_action), .cfg_target(cfg_target), .cfg_limit(cfg_limit),
    .trig_pulse(trig_pulse), .triggered(triggered), .cur_level(cur_level)
  );

  // ---------------- behavioural reference ----------------
  int m_mask [L][B];
  int m_val  [L][B];
  int m_qen  [L][B];
  int m_tmo  [L][B];
  int m_act  [L][B];
  int m_tgt  [L][B];
  int m_lim  [L];
  int m_lvl, m_cnt, m_trg, m_pulse;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 0; m_cnt = 0; m_trg = 0; m_pulse = 0;
      for (int l = 0; l < L; l++) begin
        m_lim[l] = 0;
        for (int b = 0; b < B; b++) begin
          m_mask[l][b] = 0; m_val[l][b] = 0; m_qen[l][b] = 0;
          m_tmo[l][b] = 0; m_act[l][b] = 0; m_tgt[l][b] = 0;
        end
      end
    end else begin
      m_pulse = 0;
      if (arm) begin
        m_lvl = 0; m_cnt = 0; m_trg = 0;
      end else if (smp_valid && m_trg == 0) begin
        int pick;
        int d;
        pick = -1;
        d = int'(smp_data);
        for (int b = 0; b < B; b++) begin
          if (pick < 0 && ((d ^ m_val[m_lvl][b]) & m_mask[m_lvl][b]) == 0 &&
              (m_qen[m_lvl][b] == 0 || smp_qual_n == 1'b0) &&
              (m_tmo[m_lvl][b] == 0 || m_cnt >= m_lim[m_lvl]))
            pick = b;
        end
        if (m_cnt < 65535) m_cnt = m_cnt + 1;
        if (pick >= 0) begin
          case (m_act[m_lvl][pick])
            0: begin m_lvl = m_tgt[m_lvl][pick]; m_cnt = 0; end
            2: m_cnt = 0;
            3: begin m_trg = 1; m_pulse = 1; end
            default: ;
          endcase
        end
      end
      if (cfg_br_we) begin
        m_mask[cfg_lvl][cfg_br] = int'(cfg_mask);
        m_val[cfg_lvl][cfg_br]  = int'(cfg_value);
        m_qen[cfg_lvl][cfg_br]  = int'(cfg_qual_en);
        m_tmo[cfg_lvl][cfg_br]  = int'(cfg_on_tmo);
        m_act[cfg_lvl][cfg_br]  = int'(cfg_action);
        m_tgt[cfg_lvl][cfg_br]  = int'(cfg_target);
      end
      if (cfg_lim_we) m_lim[cfg_lvl] = int'(cfg_limit);
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one cycle: compare against the model at the falling edge, then idle inputs
  task automatic tick();
    @(negedge clk);
    chk("R5 R9 model level", int'(cur_level), m_lvl);
    chk("R9 model flag", int'(triggered), m_trg);
    chk("R9 model pulse", int'(trig_pulse), m_pulse);
    arm = 1'b0; smp_valid = 1'b0; cfg_br_we = 1'b0; cfg_lim_we = 1'b0;
  endtask

  task automatic wr_br(input int l, input int b, input int mask, input int val,
                       input bit qen, input bit tmo, input int act, input int tgt);
    tick();
    cfg_br_we = 1'b1; cfg_lvl = LW'(l); cfg_br = BW'(b);
    cfg_mask = DW'(mask); cfg_value = DW'(val); cfg_qual_en = qen;
    cfg_on_tmo = tmo; cfg_action = 2'(act); cfg_target = LW'(tgt);
  endtask

  task automatic wr_lim(input int l, input int lim);
    tick();
    cfg_lim_we = 1'b1; cfg_lvl = LW'(l); cfg_limit = CW'(lim);
  endtask

  task automatic smp(input int d, input bit qn);
    tick();
    smp_valid = 1'b1; smp_data = DW'(d); smp_qual_n = qn;
  endtask

  task automatic do_arm();
    tick();
    arm = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 level", int'(cur_level), 0);
    chk("R1 flag", int'(triggered), 0);
    chk("R1 pulse", int'(trig_pulse), 0);

    // level 0: 0xABC on low 12 bits -> level 1; otherwise nothing matches (R11)
    wr_br(0, 0, 'h0FFF, 'h0ABC, 0, 0, 0, 1);
    wr_br(0, 1, 'hFFFF, 'h7777, 0, 0, 0, 3);
    // R12: sample right after the write uses the new setup
    smp('h0123, 1);
    tick();
    chk("R11 no hit stays", int'(cur_level), 0);
    // R2: matching data without strobe does nothing
    tick(); smp_valid = 1'b0; smp_data = 'h0ABC;
    tick();
    chk("R2 no strobe", int'(cur_level), 0);
    // R3 / R5: masked match jumps
    smp('hFABC, 1);
    tick();
    chk("R5 goto level1", int'(cur_level), 1);

    // level 1: qualified match -> level 2; branch1 stays (R6)
    wr_br(1, 0, 'hFFFF, 'h1234, 1, 0, 0, 2);
    wr_br(1, 1, 'h0000, 'h0000, 0, 0, 1, 0);
    smp('h1234, 1);
    tick();
    chk("R3 qualifier off", int'(cur_level), 1);
    chk("R6 stay", int'(triggered), 0);
    smp('h1234, 0);
    tick();
    chk("R3 qualifier on", int'(cur_level), 2);

    // level 2: both branches true, branch 0 wins (R4)
    wr_br(2, 0, 'h00FF, 'h0055, 0, 0, 0, 3);
    wr_br(2, 1, 'h0000, 'h0000, 0, 0, 3, 0);
    smp('h1155, 1);
    tick();
    chk("R4 priority level", int'(cur_level), 3);
    chk("R4 priority no fire", int'(triggered), 0);

    // level 3: refresh pattern clears counter, timeout fires (R7 R8)
    wr_br(3, 0, 'hFFFF, 'h5A5A, 0, 0, 2, 0);
    wr_br(3, 1, 'h0000, 'h0000, 0, 1, 3, 0);
    wr_lim(3, 5);
    // counter counted nothing during idle: entered level 3 with 0
    for (int i = 0; i < 3; i++) smp('h0000, 1);
    smp('h5A5A, 1);
    for (int i = 0; i < 5; i++) smp('h0000, 1);
    tick();
    chk("R7 clear restarts count", int'(triggered), 0);
    smp('h0000, 1);
    tick();
    chk("R8 timeout pulse", int'(trig_pulse), 1);
    chk("R9 flag set", int'(triggered), 1);
    tick();
    chk("R9 pulse one cycle", int'(trig_pulse), 0);
    // R9 frozen after trigger
    smp('h5A5A, 1);
    tick();
    chk("R9 frozen level", int'(cur_level), 3);
    chk("R9 sticky", int'(triggered), 1);

    // R10 arm
    do_arm();
    tick();
    chk("R10 arm level", int'(cur_level), 0);
    chk("R10 arm flag", int'(triggered), 0);
    // R10 arm wins over a firing sample
    wr_br(0, 0, 'h0000, 'h0000, 0, 0, 3, 0);
    tick(); arm = 1'b1; smp_valid = 1'b1; smp_data = 'h0;
    tick();
    chk("R10 arm priority flag", int'(triggered), 0);
    chk("R10 arm priority pulse", int'(trig_pulse), 0);

    // random phase, compared to the model each cycle
    for (int l = 0; l < L; l++) begin
      for (int b = 0; b < B; b++)
        wr_br(l, b, $urandom_range(0, 7), $urandom_range(0, 7), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 3));
      wr_lim(l, $urandom_range(0, 6));
    end
    do_arm();
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 2) do_arm();
      else if (r < 4)
        wr_br($urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 7),
              $urandom_range(0, 7), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              $urandom_range(0, 3), $urandom_range(0, 3));
      else if (r < 5) wr_lim($urandom_range(0, 3), $urandom_range(0, 6));
      else if (r < 75) smp($urandom_range(0, 7), 1'($urandom_range(0, 1)));
      else tick();
    end
    tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule